// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into one asynchronous serial frame on a single line. Each character arrives on a valid/ready handshake. At the moment it is accepted, the block captures the character and three run-time format controls: a character-length code, a parity code and a stop-length flag. From then on it plays out the frame at a rate set by a baud tick pulse, which an external divider provides. Every bit on the line spans sixteen ticks.

The line idles high. A frame is made of these parts, in this order:
- a low start bit;
- the data bits, least significant first;
- an optional parity bit;
- one or two high stop bits.

The block holds one character at a time. It raises ready again only once the final stop bit has run its full length. Format codes that have no defined meaning fall back to safe defaults: eight data bits, and no parity.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, tx_o is 1, ready_o is 1 and busy_o is 0.
- R2: A frame opens with tx_o at 0 for exactly 16 tick_i pulses. tx_o changes only in the clock cycle that follows a cycle with tick_i high, and every later bit also spans 16 ticks.
- R3: Data bits go out least significant bit first, with data bit i as the i-th bit after the start bit. size_code_i selects the count: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9.
- R4: A size_code_i of 100, 101 or 110 gives 8 data bits.
- R5: parity_mode_i 10 adds one bit after the data that makes the count of ones over the sent data bits plus parity even. parity_mode_i 11 adds a bit that makes that count odd.
- R6: parity_mode_i 00, and the unused code 01, add no parity bit, so the stop bits follow the last data bit directly.
- R7: stop_sel_i 0 ends the frame with one high stop bit, and stop_sel_i 1 ends it with two.
- R8: Data, size, parity and stop selections are captured in the cycle where valid_i and ready_o are both 1. Changing these inputs afterwards has no effect on the frame in flight.
- R9: ready_o falls in the cycle after an accept and stays 0, with busy_o 1, until the 16th tick of the last stop bit. Then it returns to 1, with tx_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| size_code_i | input | 3 | Character length code |
| parity_mode_i | input | 2 | Parity code |
| stop_sel_i | input | 1 | Stop length: 0 gives one bit, 1 gives two |
| data_i | input | 9 | Character to send, right aligned |
| valid_i | input | 1 | A character is offered |
| ready_o | output | 1 | The block can accept a character |
| tick_i | input | 1 | Baud tick pulse, one clock wide |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | A frame is in progress |

## Verification
The assertions assume tick_i is a synchronous pulse that is low during reset. They also assume valid_i reaches the block only through the handshake, so the line may move only on tick boundaries. The stimulus generates tick_i on every other cycle and changes all other inputs only on falling clock edges. It lowers valid_i right after the accept. It then scrambles every format and data input while the frame is in flight, so that only the values captured at accept can explain what appears on the line.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/sftx_cfg_decode.sv
module sftx_cfg_decode #(
  parameter int DATA_W = 9,
  localparam int NB_W = $clog2(DATA_W + 1)
) (
  input  logic [2:0]      size_code_i,
  input  logic [1:0]      parity_mode_i,
  output logic [NB_W-1:0] n_bits_o,
  output logic            par_en_o,
  output logic            par_odd_o
);
  always_comb begin
    unique case (size_code_i)
      3'b000:  n_bits_o = NB_W'(5);
      3'b001:  n_bits_o = NB_W'(6);
      3'b010:  n_bits_o = NB_W'(7);
      3'b111:  n_bits_o = NB_W'(DATA_W);
      default: n_bits_o = NB_W'(8); // 011 and unused codes
    endcase
  end

  // 01 is unused and falls back to no parity
  assign par_en_o  = parity_mode_i[1];
  assign par_odd_o = parity_mode_i[1] & parity_mode_i[0];
endmodule

// File: rtl/sftx_shift.sv
module sftx_shift #(
  parameter int DATA_W = 9,
  localparam int NB_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NB_W-1:0]   n_bits_i,
  input  logic              par_odd_i,
  output logic              bit_o,
  output logic              par_o
);
  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] masked;
  logic              par_q;

  // Only the bits that will be sent count towards parity
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign masked[g] = data_i[g] & (NB_W'(g) < n_bits_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      par_q <= 1'b0;
    end else if (load_i) begin
      sr_q  <= data_i;
      par_q <= (^masked) ^ par_odd_i;
    end else if (shift_i) begin
      sr_q <= {1'b0, sr_q[DATA_W-1:1]};
    end
  end

  assign bit_o = sr_q[0];
  assign par_o = par_q;
endmodule

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TICKS_PER_BIT = 16,
  localparam int NB_W = $clog2(DATA_W + 1),
  localparam int CNT_W = $clog2(TICKS_PER_BIT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            accept_i,
  input  logic [NB_W-1:0] n_bits_i,
  input  logic            par_en_i,
  input  logic            two_stop_i,
  output tx_state_e       state_o,
  output logic            shift_o
);
  tx_state_e       state_q, state_d;
  logic [CNT_W-1:0] tick_cnt_q, tick_cnt_d;
  logic [NB_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic [NB_W-1:0]  n_bits_q;
  logic             par_en_q, two_stop_q, second_q, second_d;
  logic             bit_done;

  assign bit_done = tick_i && (tick_cnt_q == CNT_W'(TICKS_PER_BIT - 1));

  always_comb begin
    state_d    = state_q;
    tick_cnt_d = tick_cnt_q;
    bit_cnt_d  = bit_cnt_q;
    second_d   = second_q;
    shift_o    = 1'b0;
    if (state_q inside {ST_START, ST_DATA, ST_PAR, ST_STOP} && tick_i)
      tick_cnt_d = bit_done ? '0 : tick_cnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE: if (accept_i) state_d = ST_WAIT;
      ST_WAIT: if (tick_i) begin
        state_d    = ST_START;
        tick_cnt_d = '0;
      end
      ST_START: if (bit_done) begin
        state_d   = ST_DATA;
        bit_cnt_d = '0;
      end
      ST_DATA: if (bit_done) begin
        shift_o = 1'b1;
        if (bit_cnt_q == n_bits_q - 1'b1) begin
          state_d  = par_en_q ? ST_PAR : ST_STOP;
          second_d = 1'b0;
        end else begin
          bit_cnt_d = bit_cnt_q + 1'b1;
        end
      end
      ST_PAR: if (bit_done) begin
        state_d  = ST_STOP;
        second_d = 1'b0;
      end
      ST_STOP: if (bit_done) begin
        if (two_stop_q && !second_q) second_d = 1'b1;
        else state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tick_cnt_q <= '0;
      bit_cnt_q  <= '0;
      second_q   <= 1'b0;
      n_bits_q   <= NB_W'(8);
      par_en_q   <= 1'b0;
      two_stop_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      tick_cnt_q <= tick_cnt_d;
      bit_cnt_q  <= bit_cnt_d;
      second_q   <= second_d;
      if (accept_i) begin
        n_bits_q   <= n_bits_i;
        par_en_q   <= par_en_i;
        two_stop_q <= two_stop_i;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TICKS_PER_BIT = 16,
  localparam int NB_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        size_code_i,
  input  logic [1:0]        parity_mode_i,
  input  logic              stop_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              tick_i,
  output logic              tx_o,
  output logic              busy_o
);
  tx_state_e       state;
  logic [NB_W-1:0] n_bits;
  logic            par_en, par_odd, accept, shift, data_bit, par_bit;

  assign accept = valid_i && (state == ST_IDLE);

  sftx_cfg_decode #(.DATA_W(DATA_W)) u_dec (
    .size_code_i  (size_code_i),
    .parity_mode_i(parity_mode_i),
    .n_bits_o     (n_bits),
    .par_en_o     (par_en),
    .par_odd_o    (par_odd)
  );

  sftx_ctrl #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .accept_i  (accept),
    .n_bits_i  (n_bits),
    .par_en_i  (par_en),
    .two_stop_i(stop_sel_i),
    .state_o   (state),
    .shift_o   (shift)
  );

  sftx_shift #(.DATA_W(DATA_W)) u_sr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .shift_i  (shift),
    .data_i   (data_i),
    .n_bits_i (n_bits),
    .par_odd_i(par_odd),
    .bit_o    (data_bit),
    .par_o    (par_bit)
  );

  always_comb begin
    unique case (state)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = data_bit;
      ST_PAR:   tx_o = par_bit;
      default:  tx_o = 1'b1;
    endcase
  end

  assign ready_o = (state == ST_IDLE);
  assign busy_o  = (state != ST_IDLE);
endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic tick_i,
  input logic ready_o,
  input logic busy_o,
  input logic tx_o
);
  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> tx_o);

  a_r2_tx_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_o != $past(tx_o)) |-> $past(tick_i));

  a_r2_start_marks_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_o) |-> busy_o);

  a_r9_drop_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  a_r9_release_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(tick_i) && tx_o));
endmodule

bind serial_frame_tx sftx_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .tick_i (tick_i),
  .ready_o(ready_o),
  .busy_o (busy_o),
  .tx_o   (tx_o)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] size_code_i = '0;
  logic [1:0] parity_mode_i = '0;
  logic       stop_sel_i = 1'b0;
  logic [8:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       ready_o, tx_o, busy_o;
  int         n_chk = 0;
  int         n_bad = 0;

  serial_frame_tx u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .size_code_i(size_code_i),
    .parity_mode_i(parity_mode_i), .stop_sel_i(stop_sel_i), .data_i(data_i),
    .valid_i(valid_i), .ready_o(ready_o), .tick_i(tick_i), .tx_o(tx_o),
    .busy_o(busy_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  initial begin
    forever begin
      @(negedge clk_i);
      tick_i = ~tick_i;
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R9 watchdog: actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk_i);
      if (tick_i) k++;
    end
  endtask

  task automatic send(input logic [8:0] d, input logic [2:0] sz, input logic [1:0] pm,
                      input logic st);
    int   nb, tot, guard;
    logic bits[16];
    logic p;
    string req;
    case (sz)
      3'b000: nb = 5;
      3'b001: nb = 6;
      3'b010: nb = 7;
      3'b111: nb = 9;
      default: nb = 8;
    endcase
    tot = 0;
    bits[tot++] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bits[tot++] = d[i];
      p ^= d[i];
    end
    if (pm == 2'b10) bits[tot++] = p;
    if (pm == 2'b11) bits[tot++] = ~p;
    bits[tot++] = 1'b1;
    if (st) bits[tot++] = 1'b1;

    @(negedge clk_i);
    data_i = d; size_code_i = sz; parity_mode_i = pm; stop_sel_i = st; valid_i = 1'b1;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    // R8: scramble inputs while the frame is in flight
    data_i = ~d; size_code_i = ~sz; parity_mode_i = ~pm; stop_sel_i = ~st;
    chk(ready_o, 1'b0, "R9", "ready after accept");
    guard = 0;
    while (tx_o !== 1'b0 && guard < 100) begin
      @(negedge clk_i);
      guard++;
    end
    chk(tx_o, 1'b0, "R2", "start edge seen");
    for (int b = 0; b < tot; b++) begin
      wait_ticks(TICKS_HALF);
      @(negedge clk_i);
      if (b == 0) req = "R2";
      else if (b <= nb) req = (sz inside {3'b100, 3'b101, 3'b110}) ? "R4" : "R3";
      else if (b == nb + 1 && pm[1]) req = "R5";
      else req = pm[1] ? "R7" : "R6";
      chk(tx_o, bits[b], req, $sformatf("bit %0d sz=%b pm=%b st=%b d=%h (R8)", b, sz, pm, st, d));
      if (b == tot - 1) chk(ready_o, 1'b0, "R9", "ready in last stop");
      wait_ticks(TICKS_HALF);
    end
    @(negedge clk_i);
    chk(ready_o, 1'b1, "R9", "ready after frame");
    chk(busy_o, 1'b0, "R1", "busy after frame");
    chk(tx_o, 1'b1, "R1", "line idle");
  endtask

  localparam int TICKS_HALF = 8;

  initial begin
    repeat (3) @(negedge clk_i);
    chk(tx_o, 1'b1, "R1", "tx in reset");
    chk(ready_o, 1'b1, "R1", "ready in reset");
    chk(busy_o, 1'b0, "R1", "busy in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tx_o, 1'b1, "R1", "tx after reset");
    for (int c = 0; c < 64; c++) begin
      logic [8:0] d;
      d = 9'((c * 37 + 5) ^ (c << 4));
      send(d, c[2:0], c[4:3], c[5]);
      send(~d, c[2:0], c[4:3], c[5]);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule